// File: doc/BRIEF.md
# GPIO controller with edge-event interrupts

This block is a 32-pin general-purpose I/O controller with a word-wide register port. Software sets each pin's direction, an open-drain option and an output level. Pins left as inputs are synchronised to the clock and copied into the data register. A change on an input pin sets a sticky event bit. Each pin can either record any change or record only falling edges.

Event bits stay set until software writes a one to them. One interrupt line is high while any event bit has its mask bit set. Pins are numbered from the most significant end: pin n lives in register bit 31 − n, in every register and on every pin vector. The register port takes one access per cycle. A write takes effect at the clock edge that samples it. A read returns data in the same cycle as the request.

Top module: `gpio_edge_top`

## Requirements
- R1: Registers sit at these byte offsets: 0x00 direction, 0x04 open-drain, 0x08 data, 0x0C event, 0x10 mask, 0x14 control. A read of any other offset returns 0. A write to any other offset changes nothing.
- R2: An access counts only when all four byte enables are 1 (`busByteEn == 4'hF`). Any other read returns 0, and any other write changes nothing.
- R3: Pin n is bit 31 − n of every register and of `pinIn`, `pinOut` and `pinOe`, so pin 0 is bit 31.
- R4: A pin whose direction bit is 1 is an output, and `pinOut` carries its data bit. A pin whose direction bit is 0 is an input. Its data bit shows the pin level three clock edges after the level is first sampled. A data write changes only the output bits.
- R5: For an input pin with control bit 0, any level change sets its event bit. With control bit 1, only a 1-to-0 change sets it.
- R6: Writing the event register clears each bit written as 1 and keeps each bit written as 0. No other cause clears an event bit.
- R7: `irq` is 1 exactly when the event register AND the mask register is nonzero, evaluated on the current register contents.
- R8: Reset clears all six registers to 0.
- R9: A level change on a pin set as output neither changes its data bit nor sets its event bit.
- R10: `pinOe` is 1 for an output pin whose open-drain bit is 0. For an output pin whose open-drain bit is 1, `pinOe` is 1 only while its data bit is 0. `pinOe` is 0 for input pins.
- R11: If an edge sets an event bit in the same cycle that a write clears it, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busValid | input | 1 | Access request this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 8 | Byte offset |
| busByteEn | input | 4 | Byte enables; all ones for an accepted access |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, same cycle as the request |
| pinIn | input | 32 | Pin levels, pin n on bit 31 − n |
| pinOut | output | 32 | Output levels |
| pinOe | output | 32 | Output enables |
| irq | output | 1 | Interrupt request |

## Verification
Read data is combinational: it is due in the same cycle as the request. A register write shows on `pinOut`, `pinOe`, `irq` and later reads from the first edge that samples it. A pin level change is first sampled at edge k and reaches the data and event registers at edge k+2. So it is visible after three edges, and the bench waits four cycles before reading. The reference model in the bench keeps the sampled pin history in a queue of depth three and applies these delays cycle by cycle. All outputs are compared 2 ns after every rising edge, when design and model have both settled. The same-cycle collision case is timed so that its clearing write lands on exactly that setting edge.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_DIR,
    SEL_ODR,
    SEL_DAT,
    SEL_EVT,
    SEL_MSK,
    SEL_CTL
  } regSel_e;

  typedef struct packed {
    logic    wrDir;
    logic    wrOdr;
    logic    wrDat;
    logic    wrEvt;
    logic    wrMsk;
    logic    wrCtl;
    regSel_e rdSel;
  } ctrlStrobe_t;

endpackage

// File: rtl/gpio_edge_decode.sv
module gpio_edge_decode
  import gpio_edge_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int BE_W   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [BE_W-1:0]   busByteEn,
  output ctrlStrobe_t       strobe
);

  localparam logic [ADDR_W-1:0] OFS_DIR = ADDR_W'(8'h00);
  localparam logic [ADDR_W-1:0] OFS_ODR = ADDR_W'(8'h04);
  localparam logic [ADDR_W-1:0] OFS_DAT = ADDR_W'(8'h08);
  localparam logic [ADDR_W-1:0] OFS_EVT = ADDR_W'(8'h0C);
  localparam logic [ADDR_W-1:0] OFS_MSK = ADDR_W'(8'h10);
  localparam logic [ADDR_W-1:0] OFS_CTL = ADDR_W'(8'h14);

  logic    fullAccess;
  logic    wrOk;
  regSel_e hitSel;

  assign fullAccess = busValid && (&busByteEn);
  assign wrOk       = fullAccess && busWrite;

  always_comb begin
    unique case (busAddr)
      OFS_DIR: hitSel = SEL_DIR;
      OFS_ODR: hitSel = SEL_ODR;
      OFS_DAT: hitSel = SEL_DAT;
      OFS_EVT: hitSel = SEL_EVT;
      OFS_MSK: hitSel = SEL_MSK;
      OFS_CTL: hitSel = SEL_CTL;
      default: hitSel = SEL_NONE;
    endcase
  end

  always_comb begin
    strobe.wrDir = wrOk && (hitSel == SEL_DIR);
    strobe.wrOdr = wrOk && (hitSel == SEL_ODR);
    strobe.wrDat = wrOk && (hitSel == SEL_DAT);
    strobe.wrEvt = wrOk && (hitSel == SEL_EVT);
    strobe.wrMsk = wrOk && (hitSel == SEL_MSK);
    strobe.wrCtl = wrOk && (hitSel == SEL_CTL);
    strobe.rdSel = (fullAccess && !busWrite) ? hitSel : SEL_NONE;
  end

  AST_ONE_WRITE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $countones({strobe.wrDir, strobe.wrOdr, strobe.wrDat,
                strobe.wrEvt, strobe.wrMsk, strobe.wrCtl}) <= 1);  // R1

  AST_NARROW_NO_EFFECT: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && (busByteEn != '1)) |->
      (!(strobe.wrDir || strobe.wrOdr || strobe.wrDat || strobe.wrEvt ||
         strobe.wrMsk || strobe.wrCtl) && strobe.rdSel == SEL_NONE));  // R2

endmodule

// File: rtl/gpio_edge_sync.sv
module gpio_edge_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [STAGES-1:0][WIDTH-1:0] stage;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stage[0] <= '0;
    else       stage[0] <= asyncIn;
  end

  for (genvar g = 1; g < STAGES; g++) begin : gen_stage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) stage[g] <= '0;
      else       stage[g] <= stage[g-1];
    end
  end

  assign syncOut = stage[STAGES-1];

endmodule

// File: rtl/gpio_edge_datapath.sv
module gpio_edge_datapath
  import gpio_edge_pkg::*;
#(
  parameter int PIN_W       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobe_t      strobe,
  input  logic [PIN_W-1:0] busWdata,
  input  logic [PIN_W-1:0] pinIn,
  output logic [PIN_W-1:0] busRdata,
  output logic [PIN_W-1:0] pinOut,
  output logic [PIN_W-1:0] pinOe,
  output logic             irq
);

  logic [PIN_W-1:0] dirQ, odrQ, datQ, evtQ, mskQ, ctlQ;
  logic [PIN_W-1:0] syncLvl, prevLvl;
  logic [PIN_W-1:0] edgeHit, datNext, clrMask;

  gpio_edge_sync #(.WIDTH(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn (pinIn),
    .syncOut (syncLvl)
  );

  // Any-edge pins see a level difference; falling-only pins see 1 then 0.
  assign edgeHit = ~dirQ & ((ctlQ & prevLvl & ~syncLvl) |
                            (~ctlQ & (prevLvl ^ syncLvl)));

  assign datNext = strobe.wrDat ? busWdata : datQ;
  assign clrMask = strobe.wrEvt ? busWdata : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dirQ    <= '0;
      odrQ    <= '0;
      datQ    <= '0;
      evtQ    <= '0;
      mskQ    <= '0;
      ctlQ    <= '0;
      prevLvl <= '0;
    end else begin
      prevLvl <= syncLvl;
      if (strobe.wrDir) dirQ <= busWdata;
      if (strobe.wrOdr) odrQ <= busWdata;
      if (strobe.wrMsk) mskQ <= busWdata;
      if (strobe.wrCtl) ctlQ <= busWdata;
      datQ <= (datNext & dirQ) | (syncLvl & ~dirQ);
      evtQ <= (evtQ & ~clrMask) | edgeHit;
    end
  end

  always_comb begin
    unique case (strobe.rdSel)
      SEL_DIR: busRdata = dirQ;
      SEL_ODR: busRdata = odrQ;
      SEL_DAT: busRdata = datQ;
      SEL_EVT: busRdata = evtQ;
      SEL_MSK: busRdata = mskQ;
      SEL_CTL: busRdata = ctlQ;
      default: busRdata = '0;
    endcase
  end

  assign pinOut = datQ & dirQ;
  assign pinOe  = dirQ & (~odrQ | ~datQ);
  assign irq    = |(evtQ & mskQ);

  AST_EVT_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.wrEvt |=> ((evtQ & $past(evtQ)) == $past(evtQ)));  // R6

  AST_EVT_INPUT_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((evtQ & ~$past(evtQ) & $past(dirQ)) == '0));  // R9

  AST_FALL_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((evtQ & ~$past(evtQ) & $past(ctlQ) & $past(syncLvl)) == '0));  // R5

  AST_OUTPUT_DATA_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.wrDat |=> (((datQ ^ $past(datQ)) & $past(dirQ)) == '0));  // R9

endmodule

// File: rtl/gpio_edge_top.sv
module gpio_edge_top
  import gpio_edge_pkg::*;
#(
  parameter int PIN_W       = 32,
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2,
  localparam int BE_W       = PIN_W / 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [BE_W-1:0]   busByteEn,
  input  logic [PIN_W-1:0]  busWdata,
  output logic [PIN_W-1:0]  busRdata,
  input  logic [PIN_W-1:0]  pinIn,
  output logic [PIN_W-1:0]  pinOut,
  output logic [PIN_W-1:0]  pinOe,
  output logic              irq
);

  ctrlStrobe_t strobe;

  gpio_edge_decode #(.ADDR_W(ADDR_W), .BE_W(BE_W)) u_decode (
    .clk       (clk),
    .rstN      (rstN),
    .busValid  (busValid),
    .busWrite  (busWrite),
    .busAddr   (busAddr),
    .busByteEn (busByteEn),
    .strobe    (strobe)
  );

  gpio_edge_datapath #(.PIN_W(PIN_W), .SYNC_STAGES(SYNC_STAGES)) u_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .busWdata (busWdata),
    .pinIn    (pinIn),
    .busRdata (busRdata),
    .pinOut   (pinOut),
    .pinOe    (pinOe),
    .irq      (irq)
  );

endmodule

// File: tb/gpio_edge_top_bench.sv
module gpio_edge_top_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busValid = 1'b0;
  logic        busWrite = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [3:0]  busByteEn = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [31:0] pinIn = '0;
  logic [31:0] pinOut;
  logic [31:0] pinOe;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  gpio_edge_top u_gpio_edge_top (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .busByteEn(busByteEn), .busWdata(busWdata),
    .busRdata(busRdata), .pinIn(pinIn), .pinOut(pinOut), .pinOe(pinOe),
    .irq(irq)
  );

  // Behavioural reference model
  logic [31:0] mDir = '0, mOdr = '0, mDat = '0, mEvt = '0, mMsk = '0, mCtl = '0;
  logic [31:0] pinHist[$] = '{32'h0, 32'h0, 32'h0};

  always @(posedge clk) begin
    logic [31:0] cur, old, newEvt, nDat;
    bit wr;
    if (!rstN) begin
      mDir = '0; mOdr = '0; mDat = '0; mEvt = '0; mMsk = '0; mCtl = '0;
      pinHist = '{32'h0, 32'h0, 32'h0};
    end else begin
      cur = pinHist[1];
      old = pinHist[2];
      newEvt = '0;
      for (int b = 0; b < 32; b++)
        if (!mDir[b])
          newEvt[b] = mCtl[b] ? (old[b] && !cur[b]) : (old[b] != cur[b]);
      wr = busValid && busWrite && (busByteEn == 4'hF);
      nDat = (wr && busAddr == 8'h08) ? busWdata : mDat;
      nDat = (nDat & mDir) | (cur & ~mDir);
      if (wr && busAddr == 8'h0C) mEvt = mEvt & ~busWdata;
      mEvt = mEvt | newEvt;
      mDat = nDat;
      if (wr && busAddr == 8'h00) mDir = busWdata;
      if (wr && busAddr == 8'h04) mOdr = busWdata;
      if (wr && busAddr == 8'h10) mMsk = busWdata;
      if (wr && busAddr == 8'h14) mCtl = busWdata;
      pinHist.push_front(pinIn);
      void'(pinHist.pop_back());
    end
  end

  function automatic logic [31:0] modelRead();
    if (!(busValid && !busWrite && busByteEn == 4'hF)) return '0;
    case (busAddr)
      8'h00: return mDir;
      8'h04: return mOdr;
      8'h08: return mDat;
      8'h0C: return mEvt;
      8'h10: return mMsk;
      8'h14: return mCtl;
      default: return '0;
    endcase
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %08h expected %08h at %0t", req, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model
  always @(posedge clk) begin
    #2;
    if (!done) begin
      check("R1 R2 read data", busRdata, modelRead());
      check("R4 pinOut", pinOut, mDat & mDir);
      check("R10 pinOe", pinOe, mDir & (~mOdr | ~mDat));
      check("R7 irq", {31'b0, irq}, {31'b0, |(mEvt & mMsk)});
    end
  end

  task automatic busWr(logic [7:0] a, logic [31:0] d, logic [3:0] be = 4'hF);
    busValid = 1'b1; busWrite = 1'b1; busAddr = a; busWdata = d; busByteEn = be;
    @(posedge clk);
    @(negedge clk);
    busValid = 1'b0; busWrite = 1'b0; busByteEn = '0;
  endtask

  task automatic busRd(string req, logic [7:0] a, logic [31:0] exp, logic [3:0] be = 4'hF);
    busValid = 1'b1; busWrite = 1'b0; busAddr = a; busByteEn = be;
    #1;
    check(req, busRdata, exp);
    @(negedge clk);
    busValid = 1'b0; busByteEn = '0;
  endtask

  task automatic summary();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R8: reset state
    busRd("R8 dir", 8'h00, 32'h0);
    busRd("R8 odr", 8'h04, 32'h0);
    busRd("R8 dat", 8'h08, 32'h0);
    busRd("R8 evt", 8'h0C, 32'h0);
    busRd("R8 msk", 8'h10, 32'h0);
    busRd("R8 ctl", 8'h14, 32'h0);
    check("R8 irq", {31'b0, irq}, 32'h0);

    // R4, R3: outputs on pins 0..15
    busWr(8'h00, 32'hFFFF0000);
    busWr(8'h08, 32'hA5A5FFFF);
    busRd("R4 data keeps input bits", 8'h08, 32'hA5A50000);
    check("R3 pin0 is bit31", {31'b0, pinOut[31]}, 32'h1);
    check("R4 pinOut", pinOut, 32'hA5A50000);

    // R10: open drain on pin 0
    busWr(8'h04, 32'h80000000);
    check("R10 released when high", pinOe, 32'h7FFF0000);
    busWr(8'h08, 32'h25A50000);
    check("R10 driven when low", pinOe, 32'hFFFF0000);

    // R2: narrow accesses
    busWr(8'h10, 32'hFFFFFFFF, 4'h1);
    busRd("R2 narrow write ignored", 8'h10, 32'h0);
    busRd("R2 narrow read zero", 8'h00, 32'h0, 4'h3);

    // R1: unmapped offset
    busWr(8'h18, 32'hFFFFFFFF);
    busRd("R1 unmapped read", 8'h18, 32'h0);
    busRd("R1 dir untouched", 8'h00, 32'hFFFF0000);

    // R5 any edge on pin 31, R7 irq with mask
    pinIn = 32'h00000001;
    repeat (4) @(negedge clk);
    busRd("R4 input sampled", 8'h08, 32'h25A50001);
    busRd("R5 any edge event", 8'h0C, 32'h00000001);
    check("R7 irq masked", {31'b0, irq}, 32'h0);
    busWr(8'h10, 32'h00000001);
    check("R7 irq unmasked", {31'b0, irq}, 32'h1);

    // R6: write-one-to-clear
    busWr(8'h0C, 32'hFFFFFFFE);
    busRd("R6 zero bits keep", 8'h0C, 32'h00000001);
    busWr(8'h0C, 32'h00000001);
    busRd("R6 one bit clears", 8'h0C, 32'h0);
    check("R7 irq drops", {31'b0, irq}, 32'h0);

    // R5: falling-only on pin 30
    busWr(8'h14, 32'h00000002);
    pinIn = 32'h00000003;
    repeat (4) @(negedge clk);
    busRd("R5 rise ignored", 8'h0C, 32'h0);
    pinIn = 32'h00000001;
    repeat (4) @(negedge clk);
    busRd("R5 fall captured", 8'h0C, 32'h00000002);
    busWr(8'h0C, 32'h00000002);

    // R9: output pin 0 toggled externally
    pinIn = 32'h80000001;
    repeat (4) @(negedge clk);
    busRd("R9 no event", 8'h0C, 32'h0);
    busRd("R9 data unchanged", 8'h08, 32'h25A50001);

    // R11: set and clear on the same edge
    pinIn = 32'h80000005;
    repeat (2) @(negedge clk);
    busWr(8'h0C, 32'h00000004);
    busRd("R11 event wins", 8'h0C, 32'h00000004);

    repeat (2) @(negedge clk);
    summary();
  end

endmodule